// File: doc/BRIEF.md
# Multi-Channel Serial Interrupt Hub

This block sits between a host bus and a bank of serial-port channels. It collects one interrupt request line per channel and merges them into a single host interrupt and a single wake line. Which channels count toward each line is set by two masks. Software never rewrites a whole mask: it writes ones to a set register to turn bits on, and ones to a clear register to turn bits off. A global status word shows the live request of every channel, so an interrupt handler can read it to find which channels need service. If no enabled channel is pending, the interrupt did not come from this block.

The hub also decodes the device address space for the channels. Each channel has a 512-byte register window, and the windows are laid out at a fixed stride above the global page. An access that falls in a channel window is passed to that channel as a byte-wide access. The address is decoded combinationally, and read data comes back in the same cycle.

Top module: `uart_irq_hub`

## Requirements
- R1: After reset, the interrupt enable mask and the wake mask are all zero, and `irq_out` and `wake_out` are low.
- R2: A read at byte offset 0x00 returns the `ID_WORD` parameter. A read at offset 0x04 returns `NCH` in bits [4:0], with the upper bits zero.
- R3: A read at offset 0x08 returns the live request lines. Bit i is channel i, and bits at and above `NCH` are zero.
- R4: Writing to offset 0x0C sets every enable-mask bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R5: Writing to offset 0x10 clears every enable-mask bit whose write-data bit is 1. A read at either 0x0C or 0x10 returns the current enable mask.
- R6: `irq_out` is high exactly when some channel has both its request and its enable bit set.
- R7: The wake mask is set through offset 0x14 and cleared through offset 0x18, with the same rules as R4 and R5. Reads at either offset return the wake mask. `wake_out` is high exactly when some channel has both its request and its wake bit set.
- R8: An access at byte address 0x1000 + 0x200*i + k, with i < `NCH` and k < 0x200, raises only `ch_sel[i]`, puts k on `ch_addr` and passes `bus_we` and `bus_wdata[7:0]` through to the channel. A read returns byte i of `ch_rdata`, zero-extended.
- R9: An access to a channel window whose index is `NCH` or higher raises no `ch_sel` bit and reads zero.
- R10: Writes to offsets 0x00, 0x04 and 0x08 change no mask. Write-data bits at and above `NCH` have no effect on either mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| ch_irq | input | NCH | Per-channel interrupt requests |
| ch_sel | output | NCH | Per-channel window select |
| ch_we | output | 1 | Write strobe to the selected channel |
| ch_addr | output | 9 | Byte offset inside the channel window |
| ch_wdata | output | 8 | Write byte to the channel |
| ch_rdata | input | NCH*8 | Read byte from each channel, channel i in bits [8i+7:8i] |
| irq_out | output | 1 | Merged host interrupt |
| wake_out | output | 1 | Merged wake request |

## Verification
Several properties are checked on every cycle:
- A set write leaves all of its ones set in the target mask.
- A clear write leaves all of its ones cleared.
- A mask holds still when no write reaches it.
- At most one channel select is high at a time.
- An out-of-range window never raises a select.

Other behaviour can only be shown by the bench's directed scenarios:
- the identification and count values;
- the exact readback through both aliases of each mask;
- how the merged lines follow the request pattern;
- the byte routing for a given window offset.

// File: rtl/uart_irq_hub.sv
module uart_irq_hub #(
  parameter int NCH = 4,
  parameter int ADDR_W = 14,
  parameter logic [31:0] ID_WORD = 32'h0950_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    ch_irq,
  output logic [NCH-1:0]    ch_sel,
  output logic              ch_we,
  output logic [8:0]        ch_addr,
  output logic [7:0]        ch_wdata,
  input  logic [NCH*8-1:0]  ch_rdata,
  output logic              irq_out,
  output logic              wake_out
);
  localparam logic [31:0] WIN_BASE = 32'h1000;
  localparam logic [31:0] WIN_END  = WIN_BASE + 32'(16 * 512);

  logic [31:0]    a32;
  logic [31:0]    win_off;
  logic [4:0]     win_idx;
  logic [9:0]     word;
  logic           is_glb, in_win, idx_ok;
  logic           gwr;
  logic           wr_ie_set, wr_ie_clr, wr_wk_set, wr_wk_clr;
  logic [NCH-1:0] wbits;
  logic [NCH-1:0] en_mask, wake_mask;
  logic [31:0]    rd;
  logic           unused_bits;

  assign a32     = 32'(bus_addr);
  assign is_glb  = a32 < WIN_BASE;
  assign in_win  = (a32 >= WIN_BASE) && (a32 < WIN_END);
  assign win_off = a32 - WIN_BASE;
  assign win_idx = win_off[13:9];
  assign idx_ok  = in_win && (win_idx < 5'(NCH));
  assign word    = a32[11:2];
  assign wbits   = bus_wdata[NCH-1:0];
  assign unused_bits = &{1'b0, bus_wdata, win_off};

  assign gwr       = bus_sel && bus_we && is_glb;
  assign wr_ie_set = gwr && word == 10'd3;
  assign wr_ie_clr = gwr && word == 10'd4;
  assign wr_wk_set = gwr && word == 10'd5;
  assign wr_wk_clr = gwr && word == 10'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask   <= '0;
      wake_mask <= '0;
    end else begin
      if (wr_ie_set) en_mask <= en_mask | wbits;
      else if (wr_ie_clr) en_mask <= en_mask & ~wbits;
      if (wr_wk_set) wake_mask <= wake_mask | wbits;
      else if (wr_wk_clr) wake_mask <= wake_mask & ~wbits;
    end
  end

  assign irq_out  = |(ch_irq & en_mask);
  assign wake_out = |(ch_irq & wake_mask);

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign ch_sel[i] = bus_sel && idx_ok && (win_idx == 5'(i));
  end
  assign ch_we    = bus_sel && bus_we && idx_ok;
  assign ch_addr  = win_off[8:0];
  assign ch_wdata = bus_wdata[7:0];

  always_comb begin
    rd = '0;
    if (is_glb) begin
      case (word)
        10'd0: rd = ID_WORD;
        10'd1: rd = {27'd0, 5'(NCH)};
        10'd2: rd = 32'(ch_irq);
        10'd3, 10'd4: rd = 32'(en_mask);
        10'd5, 10'd6: rd = 32'(wake_mask);
        default: rd = '0;
      endcase
    end else if (idx_ok) begin
      for (int i = 0; i < NCH; i++)
        if (win_idx == 5'(i)) rd = 32'(ch_rdata[i*8 +: 8]);
    end
  end
  assign bus_rdata = bus_sel ? rd : '0;

  // R4
  ie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ie_set |=> ((en_mask & $past(wbits)) == $past(wbits)));
  // R5
  ie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ie_clr |=> ((en_mask & $past(wbits)) == '0));
  // R7
  wk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wk_set |=> ((wake_mask & $past(wbits)) == $past(wbits)));
  // R10
  ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ie_set || wr_ie_clr) |=> $stable(en_mask));
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));
  // R9
  oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && win_idx >= 5'(NCH)) |-> (ch_sel == '0 && bus_rdata == '0));
endmodule

// File: tb/uart_irq_hub_tb.sv
module uart_irq_hub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam logic [31:0] ID = 32'h0950_0001;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] ch_irq = '0, ch_sel;
  logic ch_we;
  logic [8:0] ch_addr;
  logic [7:0] ch_wdata;
  logic [NCH*8-1:0] ch_rdata = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
  logic irq_out, wake_out;
  int checks = 0, errors = 0;
  bit done = 0;

  uart_irq_hub #(.NCH(NCH), .ADDR_W(14), .ID_WORD(ID)) u_dut (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .ch_irq, .ch_sel, .ch_we, .ch_addr, .ch_wdata, .ch_rdata,
    .irq_out, .wake_out);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(14'h0C, d); chk("R1 enable", d, 0);
    rd(14'h14, d); chk("R1 wake", d, 0);
    ch_irq = 4'hF; #1;
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 wake_out", 32'(wake_out), 0);
    ch_irq = 0;
  endtask

  task automatic t_ident;
    logic [31:0] d;
    rd(14'h00, d); chk("R2 id", d, ID);
    rd(14'h04, d); chk("R2 count", d, 32'd4);
    ch_irq = 4'b1010;
    rd(14'h08, d); chk("R3 status", d, 32'hA);
    ch_irq = 4'b0001;
    rd(14'h08, d); chk("R3 status live", d, 32'h1);
    ch_irq = 0;
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(14'h0C, 32'h5); rd(14'h0C, d); chk("R4 set", d, 32'h5);
    wr(14'h0C, 32'h2); rd(14'h0C, d); chk("R4 keep", d, 32'h7);
    wr(14'h10, 32'h4); rd(14'h10, d); chk("R5 clear alias", d, 32'h3);
    rd(14'h0C, d); chk("R5 clear", d, 32'h3);
    @(negedge clk) ch_irq = 4'b0100; #1 chk("R6 masked", 32'(irq_out), 0);
    @(negedge clk) ch_irq = 4'b0010; #1 chk("R6 enabled", 32'(irq_out), 1);
    ch_irq = 0; #1 chk("R6 idle", 32'(irq_out), 0);
  endtask

  task automatic t_wake;
    logic [31:0] d;
    wr(14'h14, 32'h8); rd(14'h18, d); chk("R7 wake set", d, 32'h8);
    @(negedge clk) ch_irq = 4'b1000;
    #1 chk("R7 wake_out", 32'(wake_out), 1);
    chk("R6 no irq for ch3", 32'(irq_out), 0);
    wr(14'h18, 32'h8); #1 chk("R7 wake cleared", 32'(wake_out), 0);
    ch_irq = 0;
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(14'h00, 32'hFFFF_FFFF); wr(14'h04, 32'hF); wr(14'h08, 32'hF);
    rd(14'h0C, d); chk("R10 ro writes", d, 32'h3);
    rd(14'h14, d); chk("R10 ro writes wake", d, 32'h0);
    wr(14'h0C, 32'hFFFF_FFF0); rd(14'h0C, d); chk("R10 high bits", d, 32'h3);
  endtask

  task automatic t_window;
    logic [31:0] d;
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 14'h1000 + 14'h400 + 14'h5; bus_wdata = 32'h5A;
    #1;
    chk("R8 sel", 32'(ch_sel), 32'h4);
    chk("R8 addr", 32'(ch_addr), 32'h5);
    chk("R8 we", 32'(ch_we), 1);
    chk("R8 wdata", 32'(ch_wdata), 32'h5A);
    bus_we = 0; bus_addr = 14'h1000 + 14'h600 + 14'h1FF;
    #1 chk("R8 read ch3", bus_rdata, 32'hA3);
    chk("R8 addr top", 32'(ch_addr), 32'h1FF);
    bus_addr = 14'h1000 + 14'hA00;
    #1 chk("R9 oob sel", 32'(ch_sel), 0);
    chk("R9 oob read", bus_rdata, 0);
    bus_we = 1;
    #1 chk("R9 oob write", {31'd0, ch_we} | 32'(ch_sel), 0);
    @(negedge clk); bus_sel = 0; bus_we = 0;
    rd(14'h1000, d); chk("R8 read ch0", d, 32'hA0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_ident; t_enable; t_wake; t_ignored; t_window;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule